// File: doc/BRIEF.md
# Buck Controller Startup and Protection Sequencer

This block is the digital supervisor of a synchronous buck regulator controller. It watches a handful of comparator and control flags and decides when the converter may switch, when the reference ramp may rise, when power-good may be reported, and when the gate logic must hold the output down. The comparators, the error amplifier, the reference DAC and the voltage thresholds are outside the block. Each of them reaches it only as a single-bit flag. The switching clock reaches it as a one-cycle tick that is synchronous to `clk`.

The block has four states. In reset, the drivers are off. In soft start, the reference ramp climbs one step per switching tick for a fixed number of ticks. In regulation, power-good follows the output monitor. The fourth state is an overvoltage lock: the high-side switch stays off and the low-side switch stays on until the supply is cycled or the enable input is toggled, and either way the converter then goes through a new soft start.

Top module: `buck_seq_top`

## Requirements
- R1: While `rst` is high and in the reset state, `por_o`=1 and `ss_active_o`, `drv_en_o`, `ov_lock_o` and `pgood_o` are 0. In the reset state `ramp_o`=0.
- R2: The block leaves reset only when the supply-above-rising-threshold flag, the enable input and the VID-valid flag are all high and the below-falling-threshold flag is low. The block then enters soft start with `ramp_o`=0, three clock edges after the flags settle.
- R3: Soft start lasts exactly `SS_CYCLES` (2048) switching ticks. During it, `ramp_o` equals the number of ticks counted so far, and clock cycles without a tick do not advance it.
- R4: `pgood_o` is 0 in reset, in soft start and in overvoltage lock. In regulation it equals the output-monitor flag, seen three edges after that flag changes.
- R5: In regulation and in overvoltage lock, `ramp_o` holds at full scale, `SS_CYCLES-1` (2047).
- R6: The below-falling-threshold flag sends the block to reset from any state.
- R7: The overvoltage flag has no effect in reset or in soft start.
- R8: The overvoltage flag in regulation enters the lock state. In that state `ov_lock_o`=1 and `drv_en_o`=0. Soft start and regulation both use `drv_en_o`=1 and `ov_lock_o`=0.
- R9: The lock stays set after the overvoltage flag drops, and it stays set while the enable input is low. It clears only on a low-then-high sequence of the enable input, which starts a new soft start, or on the falling-threshold flag, which sends the block to reset.
- R10: A low enable input during soft start or regulation sends the block to reset.
- R11: Once the block is out of reset, a drop of the rising-threshold flag alone (falling-threshold flag still low) has no effect. This gives the supply check its hysteresis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_above_on_i | input | 1 | Supply above rising threshold (asynchronous) |
| sup_below_off_i | input | 1 | Supply below falling threshold (asynchronous) |
| out_en_i | input | 1 | Output enable (asynchronous) |
| vid_ok_i | input | 1 | VID code valid (asynchronous) |
| ovp_i | input | 1 | Output above overvoltage limit (asynchronous) |
| vout_good_i | input | 1 | Output-voltage monitor good (asynchronous) |
| sw_tick_i | input | 1 | One-cycle switching-clock tick, synchronous |
| por_o | output | 1 | Reset state active |
| ss_active_o | output | 1 | Soft start in progress |
| ramp_o | output | RW (11) | Soft-start reference ramp value |
| pgood_o | output | 1 | Power good |
| drv_en_o | output | 1 | Both gate drivers may switch |
| ov_lock_o | output | 1 | Force high side off, low side on |

## Verification
A wrong state register shows at the ports within one clock edge, because every output decodes the state directly. A stuck or skipped state shows up as a forbidden combination of `por_o`, `drv_en_o` and `ov_lock_o`, or as `pgood_o` rising outside regulation. A soft-start counter that miscounts only shows as a ramp that breaks the one-step rule, or as regulation that starts earlier or later than the 2048th tick. The bench therefore tracks the ramp against its own tick count on every cycle. A lock that clears too early is caught within the three-edge synchronizer latency of the enable or overvoltage change that releases it.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;
  typedef enum logic [1:0] {
    ST_RST  = 2'd0,
    ST_SOFT = 2'd1,
    ST_RUN  = 2'd2,
    ST_OVL  = 2'd3
  } seq_state_e;

  localparam int unsigned NFLAG   = 6;
  localparam int unsigned F_ON    = 0;
  localparam int unsigned F_OFF   = 1;
  localparam int unsigned F_OE    = 2;
  localparam int unsigned F_VID   = 3;
  localparam int unsigned F_OV    = 4;
  localparam int unsigned F_MON   = 5;
endpackage

// File: rtl/buck_seq_sync.sv
module buck_seq_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '0;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/buck_seq_ramp.sv
module buck_seq_ramp #(
  parameter int unsigned SS_CYCLES = 2048,
  localparam int unsigned RW       = $clog2(SS_CYCLES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load_full,
  input  logic          inc,
  output logic [RW-1:0] cnt,
  output logic          at_top
);
  localparam logic [RW-1:0] TOPV = RW'(SS_CYCLES - 1);

  always_ff @(posedge clk) begin
    if (rst || clr)     cnt <= '0;
    else if (load_full) cnt <= TOPV;
    else if (inc)       cnt <= cnt + RW'(1);
  end

  assign at_top = (cnt == TOPV);
endmodule

// File: rtl/buck_seq_fsm.sv
module buck_seq_fsm
  import buck_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic on_s,
  input  logic off_s,
  input  logic oe_s,
  input  logic vid_s,
  input  logic ov_s,
  input  logic mon_s,
  input  logic tick,
  input  logic at_top,
  output logic ramp_clr,
  output logic ramp_full,
  output logic ramp_inc,
  output logic por_q,
  output logic ss_q,
  output logic drv_q,
  output logic lock_q,
  output logic pg_q
);
  seq_state_e st, st_n;
  logic       oe_seen_low;

  always_comb begin
    st_n = st;
    unique case (st)
      ST_RST:  if (on_s && !off_s && oe_s && vid_s) st_n = ST_SOFT;
      ST_SOFT: if (off_s || !oe_s)                  st_n = ST_RST;
               else if (tick && at_top)             st_n = ST_RUN;
      ST_RUN:  if (off_s || !oe_s)                  st_n = ST_RST;
               else if (ov_s)                       st_n = ST_OVL;
      ST_OVL:  if (off_s)                           st_n = ST_RST;
               else if (oe_seen_low && oe_s)        st_n = ST_SOFT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_RST;
    else     st <= st_n;
  end

  always_ff @(posedge clk) begin
    if (rst || st != ST_OVL) oe_seen_low <= 1'b0;
    else if (!oe_s)          oe_seen_low <= 1'b1;
  end

  always_comb begin
    ramp_clr  = (st_n == ST_RST) || (st_n == ST_SOFT && st != ST_SOFT);
    ramp_full = (st_n == ST_RUN) || (st_n == ST_OVL);
    ramp_inc  = (st_n == ST_SOFT) && (st == ST_SOFT) && tick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      por_q  <= 1'b1;
      ss_q   <= 1'b0;
      drv_q  <= 1'b0;
      lock_q <= 1'b0;
      pg_q   <= 1'b0;
    end else begin
      por_q  <= (st_n == ST_RST);
      ss_q   <= (st_n == ST_SOFT);
      drv_q  <= (st_n == ST_SOFT) || (st_n == ST_RUN);
      lock_q <= (st_n == ST_OVL);
      pg_q   <= (st_n == ST_RUN) && mon_s;
    end
  end
endmodule

// File: rtl/buck_seq_top.sv
module buck_seq_top
  import buck_seq_pkg::*;
#(
  parameter int unsigned SS_CYCLES   = 2048,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned RW         = $clog2(SS_CYCLES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sup_above_on_i,
  input  logic          sup_below_off_i,
  input  logic          out_en_i,
  input  logic          vid_ok_i,
  input  logic          ovp_i,
  input  logic          vout_good_i,
  input  logic          sw_tick_i,
  output logic          por_o,
  output logic          ss_active_o,
  output logic [RW-1:0] ramp_o,
  output logic          pgood_o,
  output logic          drv_en_o,
  output logic          ov_lock_o
);
  logic [NFLAG-1:0] raw, syn;
  logic clr, full, inc, at_top;

  always_comb begin
    raw        = '0;
    raw[F_ON]  = sup_above_on_i;
    raw[F_OFF] = sup_below_off_i;
    raw[F_OE]  = out_en_i;
    raw[F_VID] = vid_ok_i;
    raw[F_OV]  = ovp_i;
    raw[F_MON] = vout_good_i;
  end

  buck_seq_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  buck_seq_fsm u_fsm (
    .clk(clk), .rst(rst),
    .on_s(syn[F_ON]), .off_s(syn[F_OFF]), .oe_s(syn[F_OE]),
    .vid_s(syn[F_VID]), .ov_s(syn[F_OV]), .mon_s(syn[F_MON]),
    .tick(sw_tick_i), .at_top(at_top),
    .ramp_clr(clr), .ramp_full(full), .ramp_inc(inc),
    .por_q(por_o), .ss_q(ss_active_o), .drv_q(drv_en_o),
    .lock_q(ov_lock_o), .pg_q(pgood_o)
  );

  buck_seq_ramp #(.SS_CYCLES(SS_CYCLES)) u_ramp (
    .clk(clk), .rst(rst), .clr(clr), .load_full(full), .inc(inc),
    .cnt(ramp_o), .at_top(at_top)
  );
endmodule

// File: rtl/buck_seq_chk.sv
module buck_seq_chk #(
  parameter int unsigned RW   = 11,
  parameter int unsigned TOPV = 2047
) (
  input logic          clk,
  input logic          rst,
  input logic          por_o,
  input logic          ss_active_o,
  input logic [RW-1:0] ramp_o,
  input logic          pgood_o,
  input logic          drv_en_o,
  input logic          ov_lock_o
);
  AST_POR_QUIET: assert property (@(posedge clk) disable iff (rst)
    por_o |-> (!drv_en_o && !pgood_o && !ov_lock_o && !ss_active_o && ramp_o == '0)); // R1
  AST_RST_EXIT: assert property (@(posedge clk) disable iff (rst)
    $fell(por_o) |-> (ss_active_o && ramp_o == '0)); // R2
  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (rst)
    (ss_active_o && $past(ss_active_o)) |->
      (ramp_o == $past(ramp_o) || ramp_o == $past(ramp_o) + RW'(1))); // R3
  AST_SS_EXIT: assert property (@(posedge clk) disable iff (rst)
    ($fell(ss_active_o) && drv_en_o) |-> ($past(ramp_o) == RW'(TOPV))); // R3
  AST_PG_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ss_active_o || ov_lock_o) |-> !pgood_o); // R4
  AST_RUN_FULL: assert property (@(posedge clk) disable iff (rst)
    ((drv_en_o && !ss_active_o) || ov_lock_o) |-> (ramp_o == RW'(TOPV))); // R5
  AST_STATE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({por_o, drv_en_o, ov_lock_o})); // R8
  AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(ov_lock_o) |-> ($past(drv_en_o) && !$past(ss_active_o))); // R7
  AST_LOCK_EXIT: assert property (@(posedge clk) disable iff (rst)
    $fell(ov_lock_o) |-> (por_o || ss_active_o)); // R9
endmodule

bind buck_seq_top buck_seq_chk #(.RW(RW), .TOPV(SS_CYCLES - 1)) u_chk (
  .clk(clk), .rst(rst), .por_o(por_o), .ss_active_o(ss_active_o),
  .ramp_o(ramp_o), .pgood_o(pgood_o), .drv_en_o(drv_en_o), .ov_lock_o(ov_lock_o)
);

// File: tb/sim_buck_seq_top.sv
module sim_buck_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int SSN  = 2048;
  localparam int FULL = SSN - 1;
  localparam int S_RST = 0, S_SOFT = 1, S_RUN = 2, S_OVL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic on = 0, off = 0, oe = 0, vid = 0, ov = 0, mon = 0, tick = 0;
  logic por, ss, pg, drv, lock;
  logic [10:0] ramp;
  int checks = 0, errs = 0;
  bit reported = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buck_seq_top u0 (
    .clk(clk), .rst(rst), .sup_above_on_i(on), .sup_below_off_i(off),
    .out_en_i(oe), .vid_ok_i(vid), .ovp_i(ov), .vout_good_i(mon),
    .sw_tick_i(tick), .por_o(por), .ss_active_o(ss), .ramp_o(ramp),
    .pgood_o(pg), .drv_en_o(drv), .ov_lock_o(lock)
  );

  function automatic logic [4:0] exp_outs(int st, logic m);
    case (st)
      S_RST:   return 5'b10000;
      S_SOFT:  return 5'b01100;
      S_RUN:   return {4'b0010, m};
      default: return 5'b00010;
    endcase
  endfunction

  function automatic int exp_ramp(int st);
    if (st == S_RST || st == S_SOFT) return 0;
    return FULL;
  endfunction

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic chk_state(string tag, int st, logic m);
    chk(tag, int'({por, ss, drv, lock, pg}), int'(exp_outs(st, m)));
    chk(tag, int'(ramp), exp_ramp(st));
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
    end
  endtask

  // R3 R4 R7: count ticks until soft start ends, tracking ramp and power-good
  task automatic run_soft(bit gaps, bit ov_noise);
    int n = 0, bad_ramp = 0, bad_pg = 0;
    logic tk;
    while (ss && n < 3000) begin
      if (int'(ramp) != n) bad_ramp++;
      if (pg) bad_pg++;
      tk = gaps ? 1'($urandom) : 1'b1;
      tick = tk;
      ov = (ov_noise && n < 2030) ? 1'($urandom) : 1'b0;
      @(posedge clk);
      if (tk) n++;
      @(negedge clk);
    end
    tick = 0;
    ov = 0;
    chk("R3 tick count", n, SSN);
    chk("R3 ramp tracking", bad_ramp, 0);
    chk("R4 pgood low in soft start", bad_pg, 0);
    chk("R7 no lock from soft start", int'(lock), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk_state("R1 reset", S_RST, 0);
    rst = 0;

    // R2 R7: any incomplete start condition keeps reset, overvoltage ignored
    for (int i = 0; i < 8; i++) begin
      logic [2:0] v;
      do v = 3'($urandom); while (v == 3'b111);
      {on, oe, vid} = v;
      ov = 1'($urandom);
      mon = 1'($urandom);
      settle();
      chk_state("R2 stay in reset", S_RST, 0);
    end
    ov = 0;
    {on, oe, vid} = 3'b111;
    off = 1;
    settle();
    chk_state("R2 falling flag blocks start", S_RST, 0);
    off = 0;
    settle();
    chk_state("R2 enter soft start", S_SOFT, 0);

    mon = 1;
    run_soft(1, 1);
    chk_state("R5 regulation full scale", S_RUN, 1);

    for (int i = 0; i < 10; i++) begin
      mon = 1'($urandom);
      settle();
      chk_state("R4 pgood follows monitor", S_RUN, mon);
    end

    on = 0;
    settle();
    chk_state("R11 hysteresis", S_RUN, mon);

    ov = 1;
    repeat (2) @(negedge clk);
    ov = 0;
    settle();
    chk_state("R8 lock entered", S_OVL, 0);
    repeat (10) @(negedge clk);
    chk_state("R9 lock sticky", S_OVL, 0);
    on = 1;
    oe = 0;
    settle();
    repeat (4) @(negedge clk);
    chk_state("R9 lock held while enable low", S_OVL, 0);
    oe = 1;
    settle();
    chk_state("R9 toggle restarts soft start", S_SOFT, 0);

    run_soft(0, 0);
    chk_state("R5 full scale again", S_RUN, mon);
    oe = 0;
    settle();
    chk_state("R10 enable low in regulation", S_RST, 0);
    oe = 1;
    settle();
    chk_state("R2 restart", S_SOFT, 0);
    repeat (50) begin
      tick = 1; @(negedge clk);
    end
    tick = 0;
    oe = 0;
    settle();
    chk_state("R10 enable low in soft start", S_RST, 0);
    oe = 1;
    settle();
    repeat (20) begin
      tick = 1; @(negedge clk);
    end
    tick = 0;
    off = 1;
    settle();
    chk_state("R6 supply drop in soft start", S_RST, 0);
    off = 0;
    settle();
    run_soft(1, 0);
    off = 1;
    settle();
    chk_state("R6 supply drop in regulation", S_RST, 0);
    off = 0;
    settle();
    run_soft(0, 0);
    ov = 1;
    settle();
    chk_state("R8 lock again", S_OVL, 0);
    off = 1;
    settle();
    chk_state("R6 R9 supply drop clears lock", S_RST, 0);
    off = 0;
    settle();
    chk_state("R9 restart after supply cycle", S_SOFT, 0);
    ov = 0;
    repeat (5) begin
      tick = 1; @(negedge clk);
    end
    tick = 0;
    rst = 1;
    @(negedge clk);
    chk_state("R1 reset mid-run", S_RST, 0);

    report();
    $finish;
  end
endmodule